// File: doc/BRIEF.md
# Cascaded Unsigned Magnitude Comparator

This block decides the ordering of two unsigned 12-bit words with a chain of identical 4-bit comparison slices. Each slice looks at one nibble of each operand and also at a three-wire relation (below, same, above) handed up from the slice under it. A slice resolves the relation from its own nibbles whenever they differ. It passes the lower result through only when its nibbles match. The lowest slice is seeded with "same", so two identical words come out as equal. The last slice's relation becomes the block's output.

Alongside the chain, the block carries a separate 8-bit comparator with no cascade wiring. It reports equality and "first operand larger" on two active-low outputs. Both paths are purely combinational: the outputs follow the inputs with no clock and no state.

Top module: `mag_cmp_cascade`

## Requirements
- R1: `a_lt_b`, `a_eq_b` and `a_gt_b` equal the unsigned comparisons `a_word < b_word`, `a_word == b_word` and `a_word > b_word` for every pair of 12-bit inputs.
- R2: Exactly one of `a_lt_b`, `a_eq_b` and `a_gt_b` is 1 for every input pair.
- R3: A slice reports "same" only when its two nibbles match and the relation from the slice below is "same".
- R4: A slice reports "above" when its operand-A nibble is larger, or when its nibbles match and the lower relation is "above".
- R5: A slice reports "below" when its operand-A nibble is smaller, or when its nibbles match and the lower relation is "below".
- R6: Nibble significance follows bit position, with bits 3:0 in the first slice, 7:4 in the second and 11:8 in the third. A difference in a higher nibble decides the result whatever the lower nibbles hold.
- R7: The first slice's incoming relation is fixed at "same", so identical words give `a_eq_b`=1 with the other two outputs at 0.
- R8: `p_eq_q_n` is 0 exactly when `p_word == q_word`, and 1 otherwise.
- R9: `p_gt_q_n` is 0 exactly when `p_word > q_word` (unsigned), and 1 otherwise.
- R10: `p_eq_q_n` and `p_gt_q_n` are never 0 at the same time, and both are 1 when `p_word < q_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | 12 | First operand of the chained comparator |
| b_word | input | 12 | Second operand of the chained comparator |
| a_lt_b | output | 1 | 1 when a_word is below b_word |
| a_eq_b | output | 1 | 1 when the operands match |
| a_gt_b | output | 1 | 1 when a_word is above b_word |
| p_word | input | 8 | First operand of the flat comparator |
| q_word | input | 8 | Second operand of the flat comparator |
| p_eq_q_n | output | 1 | Active-low equality of p_word and q_word |
| p_gt_q_n | output | 1 | Active-low "p_word larger" flag |

## Verification
The relation passes through the lower slices only when the two upper nibbles match, and random operands produce that case in about one pair in 256. The stimulus therefore holds the upper eight bits equal at several fixed values and sweeps all 256 combinations of the low nibble. This drives the seeded first slice's result up through two slices that must pass it unchanged. Table vectors whose upper nibbles differ by one while the lower nibbles point the other way check that higher significance wins.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

  localparam rel_t REL_SAME = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_nib,
  input  logic [W-1:0] b_nib,
  input  rel_t         casc_in,
  output rel_t         casc_out
);
  logic nib_same;
  logic nib_above;
  logic nib_below;

  always_comb begin
    nib_same  = (a_nib == b_nib);
    nib_above = (a_nib > b_nib);
    nib_below = (a_nib < b_nib);
    // a local difference overrides whatever arrives from below
    casc_out.eq = nib_same & casc_in.eq;
    casc_out.gt = nib_above | (nib_same & casc_in.gt);
    casc_out.lt = nib_below | (nib_same & casc_in.lt);
  end
endmodule

// File: rtl/cmp_flat.sv
module cmp_flat #(
  parameter int W = 8
) (
  input  logic [W-1:0] p_val,
  input  logic [W-1:0] q_val,
  output logic         eq_n,
  output logic         gt_n
);
  always_comb begin
    eq_n = ~(p_val == q_val);
    gt_n = ~(p_val > q_val);
  end
endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import cmp_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3,
  parameter int FLAT_W     = 8
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] a_word,
  input  logic [SLICE_W*NUM_SLICES-1:0] b_word,
  output logic                          a_lt_b,
  output logic                          a_eq_b,
  output logic                          a_gt_b,
  input  logic [FLAT_W-1:0]             p_word,
  input  logic [FLAT_W-1:0]             q_word,
  output logic                          p_eq_q_n,
  output logic                          p_gt_q_n
);
  localparam int TOTAL_W = SLICE_W * NUM_SLICES;

  // link[i] is the relation entering slice i; link[NUM_SLICES] is the result
  rel_t [NUM_SLICES:0] link;

  assign link[0] = REL_SAME;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) u_slice (
      .a_nib   (a_word[g*SLICE_W +: SLICE_W]),
      .b_nib   (b_word[g*SLICE_W +: SLICE_W]),
      .casc_in (link[g]),
      .casc_out(link[g+1])
    );
  end

  assign a_lt_b = link[NUM_SLICES].lt;
  assign a_eq_b = link[NUM_SLICES].eq;
  assign a_gt_b = link[NUM_SLICES].gt;

  cmp_flat #(.W(FLAT_W)) u_flat (
    .p_val(p_word),
    .q_val(q_word),
    .eq_n (p_eq_q_n),
    .gt_n (p_gt_q_n)
  );

  logic unused_w;
  assign unused_w = (TOTAL_W == 0);
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk
  import cmp_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3,
  parameter int FLAT_W     = 8
) (
  input logic [SLICE_W*NUM_SLICES-1:0] a_word,
  input logic [SLICE_W*NUM_SLICES-1:0] b_word,
  input logic                          a_lt_b,
  input logic                          a_eq_b,
  input logic                          a_gt_b,
  input logic [FLAT_W-1:0]             p_word,
  input logic [FLAT_W-1:0]             q_word,
  input logic                          p_eq_q_n,
  input logic                          p_gt_q_n,
  input rel_t [NUM_SLICES:0]           link
);
  always_comb begin
    a_r1_order_matches: assert ((a_lt_b == (a_word < b_word)) &&
                                (a_eq_b == (a_word == b_word)) &&
                                (a_gt_b == (a_word > b_word)))
      else $error("R1 chain result disagrees with unsigned compare");
    a_r2_single_relation: assert ($countones({a_lt_b, a_eq_b, a_gt_b}) == 1)
      else $error("R2 relation outputs not exactly one");
    for (int i = 0; i < NUM_SLICES; i++) begin
      // R3: "same" out of a slice implies "same" into it
      a_r3_same_needs_lower: assert (!link[i+1].eq || link[i].eq)
        else $error("R3 slice %0d reports same without lower same", i);
      // R4/R5: with matching nibbles the lower relation passes unchanged
      a_r4_pass_above: assert (!(a_word[i*SLICE_W +: SLICE_W] == b_word[i*SLICE_W +: SLICE_W])
                               || (link[i+1].gt == link[i].gt))
        else $error("R4 slice %0d altered above on equal nibbles", i);
      a_r5_pass_below: assert (!(a_word[i*SLICE_W +: SLICE_W] == b_word[i*SLICE_W +: SLICE_W])
                               || (link[i+1].lt == link[i].lt))
        else $error("R5 slice %0d altered below on equal nibbles", i);
    end
    a_r8_flat_equal: assert (p_eq_q_n == (p_word != q_word))
      else $error("R8 flat equality wrong");
    a_r9_flat_above: assert (p_gt_q_n == !(p_word > q_word))
      else $error("R9 flat above flag wrong");
    a_r10_flat_exclusive: assert (p_eq_q_n || p_gt_q_n)
      else $error("R10 both flat outputs asserted");
  end
endmodule

bind mag_cmp_cascade cmp_chain_chk #(
  .SLICE_W   (SLICE_W),
  .NUM_SLICES(NUM_SLICES),
  .FLAT_W    (FLAT_W)
) u_chk (
  .a_word  (a_word),
  .b_word  (b_word),
  .a_lt_b  (a_lt_b),
  .a_eq_b  (a_eq_b),
  .a_gt_b  (a_gt_b),
  .p_word  (p_word),
  .q_word  (q_word),
  .p_eq_q_n(p_eq_q_n),
  .p_gt_q_n(p_gt_q_n),
  .link    (link)
);

// File: tb/tb_mag_cmp_cascade.sv
module tb_mag_cmp_cascade;
  localparam int NV = 14;
  // {a, b, expected {lt,eq,gt}}
  localparam logic [26:0] VEC [NV] = '{
    {12'h000, 12'h000, 3'b010},  // R7 all zero
    {12'hFFF, 12'hFFF, 3'b010},  // R7 all ones
    {12'h001, 12'h000, 3'b001},  // R4 low nibble
    {12'h000, 12'h001, 3'b100},  // R5 low nibble
    {12'h100, 12'h0FF, 3'b001},  // R6 top beats lower
    {12'h0FF, 12'h100, 3'b100},  // R6
    {12'hA5C, 12'hA5B, 3'b001},  // R4
    {12'hA5B, 12'hA5C, 3'b100},  // R5
    {12'h800, 12'h7FF, 3'b001},  // R6 msb
    {12'h7FF, 12'h800, 3'b100},  // R6
    {12'h350, 12'h34F, 3'b001},  // R6 middle decides
    {12'h34F, 12'h350, 3'b100},  // R6
    {12'hFFE, 12'hFFF, 3'b100},  // R1
    {12'h0F0, 12'h0F0, 3'b010}   // R3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_word = '0;
  logic [11:0] b_word = '0;
  logic [7:0]  p_word = '0;
  logic [7:0]  q_word = '0;
  logic        a_lt_b, a_eq_b, a_gt_b, p_eq_q_n, p_gt_q_n;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  mag_cmp_cascade dut (
    .a_word(a_word), .b_word(b_word),
    .a_lt_b(a_lt_b), .a_eq_b(a_eq_b), .a_gt_b(a_gt_b),
    .p_word(p_word), .q_word(q_word),
    .p_eq_q_n(p_eq_q_n), .p_gt_q_n(p_gt_q_n)
  );

  task automatic drive(input logic [11:0] a, input logic [11:0] b,
                       input logic [7:0] p, input logic [7:0] q);
    @(posedge clk);
    #1;
    a_word = a; b_word = b; p_word = p; q_word = q;
    #1;
  endtask

  task automatic check_wide(input logic [2:0] exp, input string tag);
    checks++;
    if ({a_lt_b, a_eq_b, a_gt_b} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%b expected=%b", tag, a_word, b_word,
               {a_lt_b, a_eq_b, a_gt_b}, exp);
    end
  endtask

  task automatic check_flat(input string tag);
    logic [1:0] exp;
    exp = {~(p_word == q_word), ~(p_word > q_word)};
    checks++;
    if ({p_eq_q_n, p_gt_q_n} !== exp || exp == 2'b00) begin
      fails++;
      $display("FAIL %s p=%h q=%h actual=%b expected=%b", tag, p_word, q_word,
               {p_eq_q_n, p_gt_q_n}, exp);
    end
  endtask

  function automatic logic [2:0] ref_rel(input logic [11:0] a, input logic [11:0] b);
    return {a < b, a == b, a > b};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset state: zero operands read as equal (R7), flat equal (R8)
    check_wide(3'b010, "R7 reset");
    check_flat("R8 reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26:15], VEC[i][14:3], 8'h00, 8'h00);
      check_wide(VEC[i][2:0], "R1/R6 table");
    end

    // only the lowest nibble differs: R3 same, R4 above, R5 below
    for (int u = 0; u < 4; u++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          logic [11:0] up;
          logic [2:0]  e;
          up = (u == 0) ? 12'h000 : (u == 1) ? 12'hFF0 : (u == 2) ? 12'h5A0 : 12'h810;
          drive(up | 12'(x), up | 12'(y), 8'h00, 8'h00);
          e = ref_rel(up | 12'(x), up | 12'(y));
          if (e[1])      check_wide(e, "R3 low nibble");
          else if (e[0]) check_wide(e, "R4 low nibble");
          else           check_wide(e, "R5 low nibble");
        end
      end
    end

    // flat corners: R8 equal, R9 above, R10 below
    drive(12'h000, 12'h000, 8'hFF, 8'hFF); check_flat("R8 corner");
    drive(12'h000, 12'h000, 8'hFF, 8'h00); check_flat("R9 corner");
    drive(12'h000, 12'h000, 8'h80, 8'h7F); check_flat("R9 msb");
    drive(12'h000, 12'h000, 8'h00, 8'hFF); check_flat("R10 below");
    drive(12'h000, 12'h000, 8'h7F, 8'h80); check_flat("R10 msb");

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] ra, rb;
      ra = 12'($urandom);
      rb = (n % 5 == 0) ? ra : 12'($urandom);
      drive(ra, rb, 8'($urandom), 8'($urandom));
      check_wide(ref_rel(ra, rb), "R1 random");
      checks++;
      if ($countones({a_lt_b, a_eq_b, a_gt_b}) != 1) begin
        fails++;
        $display("FAIL R2 actual=%b expected=one bit set", {a_lt_b, a_eq_b, a_gt_b});
      end
      check_flat("R8/R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule